// File: doc/BRIEF.md
# I2C Read-Only Target with Host Transmit Handshake

This block is an I2C target that only sends data. It samples SDA and SCL through synchronizers. After each start condition it compares the first frame it receives with a 7-bit device address that the host programs. When the address matches, it acknowledges at a level the host chooses. If the frame's direction bit asks for a read, the block enters transmit mode by itself. Bytes then stream to the bus controller from a one-byte transmit holding register that the host fills.

The host side is a plain register port. The host writes a byte with a one-cycle write strobe. It watches an empty flag that says when the next byte can be written, and an end flag that says the last byte has left. When no byte is waiting at the end of an acknowledged byte, the block stretches the clock by holding SCL low. To finish a transfer, the host clears transmit mode and then performs a dummy read of the receive byte register. Only after that read is SCL let go. Both bus lines are driven open-drain: each output only asks for the line to be pulled low.

Top module: `i2c_tx_slave`

## Requirements
- R1: After reset, neither bus line is pulled (`scl_pull_o` = 0, `sda_pull_o` = 0), `tx_empty_o` = 1, `tx_end_o` = 0 and `xmit_mode_o` = 0.
- R2: Only the first frame after a start condition is compared with `own_addr_i`. The frame's upper 7 bits are the address and bit 0 is the direction, where 1 means read. On a mismatch the block pulls neither line until the next start condition.
- R3: On an address match, the block drives SDA during the 9th SCL clock of the address frame to the level given by `ack_lvl_i`. A value of 0 pulls SDA low (acknowledge). A value of 1 leaves SDA released.
- R4: An acknowledged read address sets `xmit_mode_o` on the 9th SCL rising edge without any host action. A matching write address, or an address answered with `ack_lvl_i` = 1, leaves `xmit_mode_o` at 0, and the block stays off the bus for the rest of that transfer.
- R5: A transmitted byte appears on SDA most significant bit first, during clocks 1 to 8. SDA changes only while SCL is low, and SDA is released for the 9th clock.
- R6: `tx_empty_o` goes to 0 on a host write (`wr_tx_i`). It returns to 1 when the byte is moved into the shift register, which happens at the SCL falling edge that starts that byte.
- R7: At the falling edge after an acknowledged 9th clock, if no byte is waiting, the block pulls SCL low. A host write while transmit mode is set releases SCL no later than the second rising `clk` edge that follows the write strobe.
- R8: `tx_end_o` sets on the 9th SCL rising edge of a data byte if `tx_empty_o` is 1 at that moment. It stays set until a `clr_tend_i` pulse.
- R9: While SCL is being held, a dummy read (`rd_rx_i`) has no effect as long as `xmit_mode_o` is 1. After `clr_xmit_i`, a dummy read releases SCL. `rx_byte_o` holds the last address frame received.
- R10: When the controller answers a data byte with NACK (SDA high on the 9th clock), the block stops driving SDA. It does not pull either line again until a stop or start condition, even if the host writes a byte meanwhile.
- R11: A stop condition (SDA rising while SCL is high) returns the block to idle and clears `xmit_mode_o`.
- R12: A repeated start, with no stop before it, restarts address comparison. A matching read that follows it is acknowledged and served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_pull_o | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| own_addr_i | input | 7 | Device address to answer |
| ack_lvl_i | input | 1 | Level driven on the address acknowledge clock (0 = ACK) |
| wr_tx_i | input | 1 | Write strobe for the transmit holding register |
| tx_byte_i | input | 8 | Byte written with `wr_tx_i` |
| clr_tend_i | input | 1 | Clears the transmit-end flag |
| clr_xmit_i | input | 1 | Host leaves transmit mode |
| rd_rx_i | input | 1 | Dummy read strobe of the receive byte register |
| rx_byte_o | output | 8 | Last received address frame |
| tx_empty_o | output | 1 | Transmit holding register is free |
| tx_end_o | output | 1 | Last byte shifted out with nothing queued |
| xmit_mode_o | output | 1 | Block is in transmit mode |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except when it makes a start or stop condition. They also assume that it never makes a start or stop while this block is driving SDA or holding SCL, and that each SCL phase lasts many system clocks. The bench controller keeps every SCL high and low phase at twenty clocks, and it moves SDA only in the low phase. It issues start and stop only while the block is silent. Host strobes are single-cycle pulses placed between clock edges. Bytes are written only when the block is idle, when it is mid-byte with the empty flag set, or when it is stretching the clock.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_ADDR,   // shifting in the address frame
        ST_AACK,   // 9th clock of the address frame
        ST_SEND,   // shifting a data byte out
        ST_MACK,   // 9th clock of a data byte, controller answers
        ST_HOLD,   // SCL held low, waiting for a byte
        ST_DRAIN,  // transmit mode left, waiting for the dummy read
        ST_SKIP    // off the bus until the next start or stop
    } i2cs_state_e;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s_i;
        prev_d.sda = sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    // SCL must be high on both samples so that an SCL edge in the same
    // cycle never reads as a bus condition.
    assign scl_rise_o = scl_s_i & ~prev_q.scl;
    assign scl_fall_o = ~scl_s_i & prev_q.scl;
    assign start_o    = scl_s_i & prev_q.scl & prev_q.sda & ~sda_s_i;
    assign stop_o     = scl_s_i & prev_q.scl & ~prev_q.sda & sda_s_i;

endmodule

// File: rtl/i2cs_txbuf.sv
module i2cs_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (take_i) begin
            buf_d.empty = 1'b1;
        end
        if (wr_i) begin
            buf_d.data  = wdata_i;
            buf_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '{data: '0, empty: 1'b1};
        end else begin
            buf_q <= buf_d;
        end
    end

    assign data_o  = buf_q.data;
    assign empty_o = buf_q.empty;

endmodule

// File: rtl/i2c_tx_slave.sv
module i2c_tx_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic [DATA_W-2:0] own_addr_i,
    input  logic              ack_lvl_i,
    input  logic              wr_tx_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              clr_tend_i,
    input  logic              clr_xmit_i,
    input  logic              rd_rx_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              tx_empty_o,
    output logic              tx_end_o,
    output logic              xmit_mode_o
);

    import i2cs_pkg::*;

    localparam int              CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FRAME = CNT_W'(DATA_W);

    typedef struct packed {
        i2cs_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic              sda_pull;
        logic              scl_pull;
        logic              xmit;
        logic              tend;
        logic              mnack;
    } core_t;

    core_t r_d, r_q;

    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_evt, stop_evt;
    logic              take;
    logic [DATA_W-1:0] hold_data;
    logic              hold_empty;
    logic              next_byte;

    i2cs_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    i2cs_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2cs_txbuf #(
        .DATA_W (DATA_W)
    ) u_txbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_tx_i),
        .wdata_i (tx_byte_i),
        .take_i  (take),
        .data_o  (hold_data),
        .empty_o (hold_empty)
    );

    always_comb begin
        r_d       = r_q;
        take      = 1'b0;
        next_byte = 1'b0;

        if (clr_tend_i) begin
            r_d.tend = 1'b0;
        end
        if (clr_xmit_i) begin
            r_d.xmit = 1'b0;
        end

        if (start_evt || stop_evt) begin
            r_d.state    = start_evt ? ST_ADDR : ST_IDLE;
            r_d.cnt      = '0;
            r_d.sda_pull = 1'b0;
            r_d.scl_pull = 1'b0;
            r_d.xmit     = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[DATA_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == FRAME) begin
                        if (r_q.sh[DATA_W-1:1] == own_addr_i) begin
                            r_d.state    = ST_AACK;
                            r_d.sda_pull = ~ack_lvl_i;
                        end else begin
                            r_d.state = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_rise) begin
                        r_d.rx = r_q.sh;
                        if (r_q.sh[0] && r_q.sda_pull) begin
                            r_d.xmit = 1'b1;
                        end
                    end else if (scl_fall) begin
                        r_d.sda_pull = 1'b0;
                        if (r_q.xmit) begin
                            next_byte = 1'b1;
                        end else begin
                            r_d.state = ST_SKIP;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == FRAME) begin
                            r_d.sda_pull = 1'b0;
                            r_d.state    = ST_MACK;
                        end else begin
                            r_d.sh       = {r_q.sh[DATA_W-2:0], 1'b0};
                            r_d.sda_pull = ~r_q.sh[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.mnack = sda_s;
                        if (hold_empty) begin
                            r_d.tend = 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (r_q.mnack) begin
                            r_d.state = ST_SKIP;
                        end else begin
                            next_byte = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!r_q.xmit) begin
                        r_d.state = ST_DRAIN;
                    end else begin
                        next_byte = 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (rd_rx_i) begin
                        r_d.scl_pull = 1'b0;
                        r_d.state    = ST_SKIP;
                    end
                end
                default: begin
                end
            endcase

            if (next_byte) begin
                if (!hold_empty) begin
                    take         = 1'b1;
                    r_d.sh       = hold_data;
                    r_d.sda_pull = ~hold_data[DATA_W-1];
                    r_d.cnt      = '0;
                    r_d.scl_pull = 1'b0;
                    r_d.state    = ST_SEND;
                end else begin
                    r_d.scl_pull = 1'b1;
                    r_d.state    = ST_HOLD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, sh: '0, rx: '0, sda_pull: 1'b0,
                     scl_pull: 1'b0, xmit: 1'b0, tend: 1'b0, mnack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_pull_o  = r_q.scl_pull;
    assign sda_pull_o  = r_q.sda_pull;
    assign rx_byte_o   = r_q.rx;
    assign tx_empty_o  = hold_empty;
    assign tx_end_o    = r_q.tend;
    assign xmit_mode_o = r_q.xmit;

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_evt,
    input logic sda_pull_o,
    input logic scl_pull_o,
    input logic tx_empty_o,
    input logic tx_end_o,
    input logic xmit_mode_o,
    input logic wr_tx_i,
    input logic clr_tend_i
);

    // R5: the data line moves only while the synchronized clock is low
    p_sda_moves_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_pull_o) |-> !$past(scl_s));

    // R4: transmit mode is entered on an SCL rising edge
    p_xmit_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xmit_mode_o) |-> $past(scl_s));

    // R6: a host write leaves the holding register occupied
    p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx_i |=> !tx_empty_o);

    // R7: a waiting byte ends clock stretching on the next cycle
    p_stretch_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_o && !tx_empty_o && xmit_mode_o) |=> !scl_pull_o);

    // R8: the end flag only drops on a clear pulse
    p_end_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end_o && !clr_tend_i) |=> tx_end_o);

    // R11: a stop condition leaves transmit mode
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !xmit_mode_o);

endmodule

bind i2c_tx_slave i2cs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .stop_evt    (stop_evt),
    .sda_pull_o  (sda_pull_o),
    .scl_pull_o  (scl_pull_o),
    .tx_empty_o  (tx_empty_o),
    .tx_end_o    (tx_end_o),
    .xmit_mode_o (xmit_mode_o),
    .wr_tx_i     (wr_tx_i),
    .clr_tend_i  (clr_tend_i)
);

// File: tb/i2c_tx_slave_test.sv
module i2c_tx_slave_test;

    localparam int H = 20;
    localparam logic [6:0] OWN = 7'h52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic scl_pull, sda_pull;
    logic [6:0] own_addr = OWN;
    logic ack_lvl = 1'b0;
    logic wr_tx = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic clr_tend = 1'b0;
    logic clr_xmit = 1'b0;
    logic rd_rx = 1'b0;
    logic [7:0] rx_byte;
    logic tx_empty, tx_end, xmit_mode;
    logic scl_bus, sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit quiet = 1'b0;
    string quiet_req = "R2";
    bit done = 1'b0;
    logic [7:0] tx_q[$];

    assign scl_bus = !(m_scl_low || scl_pull);
    assign sda_bus = !(m_sda_low || sda_pull);

    always #5 clk = ~clk;

    i2c_tx_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_bus),
        .sda_i       (sda_bus),
        .scl_pull_o  (scl_pull),
        .sda_pull_o  (sda_pull),
        .own_addr_i  (own_addr),
        .ack_lvl_i   (ack_lvl),
        .wr_tx_i     (wr_tx),
        .tx_byte_i   (tx_byte),
        .clr_tend_i  (clr_tend),
        .clr_xmit_i  (clr_xmit),
        .rd_rx_i     (rd_rx),
        .rx_byte_o   (rx_byte),
        .tx_empty_o  (tx_empty),
        .tx_end_o    (tx_end),
        .xmit_mode_o (xmit_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    endtask

    // The target must stay off the bus while the model says so.
    always @(negedge clk) begin
        if (rst_n && quiet) begin
            n_chk++;
            if (sda_pull || scl_pull) begin
                n_bad++;
                $display("FAIL %s: actual pulls %b%b expected 00", quiet_req, scl_pull, sda_pull);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_bus) tick(1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0;
        tick(H);
        m_scl_low = 1'b0;
        wait_high();
        tick(H);
        m_sda_low = 1'b1;
        tick(H);
        m_scl_low = 1'b1;
        tick(4);
    endtask

    task automatic bus_stop();
        m_scl_low = 1'b1;
        tick(H);
        m_sda_low = 1'b1;
        tick(H);
        m_scl_low = 1'b0;
        wait_high();
        tick(H);
        m_sda_low = 1'b0;
        tick(H);
    endtask

    task automatic put_bit(input logic b);
        m_sda_low = !b;
        tick(H);
        m_scl_low = 1'b0;
        wait_high();
        tick(H);
        m_scl_low = 1'b1;
        tick(4);
    endtask

    task automatic get_bit(output logic b);
        m_sda_low = 1'b0;
        tick(H);
        m_scl_low = 1'b0;
        wait_high();
        tick(H / 2);
        b = sda_bus;
        tick(H / 2);
        m_scl_low = 1'b1;
        tick(4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v = {v[6:0], b};
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        tx_byte = v;
        wr_tx = 1'b1;
        tx_q.push_back(v);
        tick(1);
        wr_tx = 1'b0;
    endtask

    task automatic pulse_clr_tend();
        clr_tend = 1'b1; tick(1); clr_tend = 1'b0;
    endtask

    task automatic pulse_clr_xmit();
        clr_xmit = 1'b1; tick(1); clr_xmit = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_rx = 1'b1; tick(1); rd_rx = 1'b0;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] got);
        logic [7:0] exp;
        exp = tx_q.pop_front();
        chk(req, got, exp);
    endtask

    initial begin
        logic       a;
        logic [7:0] v;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 tx_end", tx_end, 0);
        chk("R1 xmit", xmit_mode, 0);

        // R2: foreign address is ignored
        quiet_req = "R2"; quiet = 1'b1;
        bus_start();
        send_byte({7'h13, 1'b1});
        get_bit(a);
        chk("R2 no ack", a, 1);
        send_byte(8'h00);
        get_bit(a);
        chk("R2 silent data", a, 1);
        chk("R2 xmit", xmit_mode, 0);
        bus_stop();
        quiet = 1'b0;

        // R3/R4: matching write address is acknowledged, no transmit
        bus_start();
        send_byte({OWN, 1'b0});
        get_bit(a);
        chk("R3 ack low", a, 0);
        chk("R4 write no xmit", xmit_mode, 0);
        quiet_req = "R4"; quiet = 1'b1;
        send_byte(8'h00);
        get_bit(a);
        chk("R4 silent after write", a, 1);
        bus_stop();

        // R3: acknowledge level 1 leaves SDA released
        ack_lvl = 1'b1;
        quiet_req = "R3";
        bus_start();
        send_byte({OWN, 1'b1});
        get_bit(a);
        chk("R3 nack level", a, 1);
        chk("R4 nacked read no xmit", xmit_mode, 0);
        bus_stop();
        quiet = 1'b0;
        ack_lvl = 1'b0;

        // Main read with streaming, stretching and end handshake
        host_write(8'hA5);
        tick(1);
        chk("R6 write clears empty", tx_empty, 0);
        bus_start();
        send_byte({OWN, 1'b1});
        get_bit(a);
        chk("R3 read ack", a, 0);
        chk("R4 auto xmit", xmit_mode, 1);
        chk("R6 empty after move", tx_empty, 1);
        host_write(8'h3C);
        tick(1);
        chk("R6 refill", tx_empty, 0);
        read_byte(v);
        expect_byte("R5 byte A5", v);
        put_bit(1'b0);
        chk("R8 no end when queued", tx_end, 0);
        chk("R6 second move", tx_empty, 1);
        read_byte(v);
        expect_byte("R5 byte 3C", v);
        put_bit(1'b0);
        chk("R8 end set", tx_end, 1);
        m_sda_low = 1'b0;
        m_scl_low = 1'b0;
        tick(50);
        chk("R7 scl held", scl_bus, 0);
        host_write(8'h81);
        tick(1);
        chk("R7 release after write", scl_pull, 0);
        read_byte(v);
        expect_byte("R5 byte 81", v);
        put_bit(1'b0);
        chk("R8 end sticky", tx_end, 1);
        m_sda_low = 1'b0;
        m_scl_low = 1'b0;
        tick(30);
        chk("R7 held again", scl_bus, 0);
        pulse_clr_tend();
        tick(2);
        chk("R8 cleared", tx_end, 0);
        pulse_rd();
        tick(5);
        chk("R9 read in xmit ignored", scl_bus, 0);
        pulse_clr_xmit();
        tick(5);
        chk("R9 xmit cleared", xmit_mode, 0);
        chk("R9 still held", scl_bus, 0);
        pulse_rd();
        tick(2);
        chk("R9 released", scl_bus, 1);
        chk("R9 rx byte", rx_byte, {OWN, 1'b1});
        bus_stop();

        // R10/R11: controller NACK ends the stream
        host_write(8'h5A);
        bus_start();
        send_byte({OWN, 1'b1});
        get_bit(a);
        chk("R3 ack again", a, 0);
        read_byte(v);
        expect_byte("R5 byte 5A", v);
        put_bit(1'b1);
        quiet_req = "R10"; quiet = 1'b1;
        host_write(8'hFF);
        for (int i = 0; i < 3; i++) begin
            get_bit(a);
            chk("R10 sda released", a, 1);
        end
        chk("R10 byte kept", tx_empty, 0);
        chk("R11 xmit before stop", xmit_mode, 1);
        bus_stop();
        quiet = 1'b0;
        chk("R11 stop clears xmit", xmit_mode, 0);
        pulse_clr_tend();

        // R12: repeated start after a foreign address
        quiet_req = "R2"; quiet = 1'b1;
        bus_start();
        send_byte({7'h11, 1'b1});
        get_bit(a);
        chk("R2 foreign", a, 1);
        quiet = 1'b0;
        bus_start();
        send_byte({OWN, 1'b1});
        get_bit(a);
        chk("R12 ack after restart", a, 0);
        read_byte(v);
        expect_byte("R12 byte FF", v);
        put_bit(1'b1);
        bus_stop();
        chk("R12 idle", xmit_mode, 0);

        report();
    end

endmodule